// File: doc/BRIEF.md
# Serial-Programmed Output Enable Controller for a Ten-Pair Clock Fan-Out

This block is the control side of a ten-pair differential clock fan-out. It contains a two-wire serial slave that answers at 7-bit address 0x6A. The address byte with its R/W bit is 0xD4 for a write and 0xD5 for a read. SCL and SDA are oversampled in a faster system clock domain. The slave accepts single-byte and block transfers into a seven-entry register map. Only entries 5 and 6 hold state, and their bits are scattered across the ten output pairs.

The ten stored enable bits are retimed into the reference clock domain on its falling edge. Each true output is the reference clock gated by its enable, and each complement output is the inverse of its true output. A pair that is switched off therefore parks with true low and complement high, and no pulse is ever cut short. A separate feedback output always follows the reference clock, and no register touches it.

Serial read data is returned by pulling SDA low through an open-drain control output.

Top module: `clkfan_ctl`

## Requirements
- R1: The address byte 0xD4 (write) or 0xD5 (read) is acknowledged. Any other address byte is NACKed, and the rest of that transaction has no effect on any register. While the slave is idle it never pulls SDA.
- R2: Byte write: START, 0xD4, a non-zero command byte N, one data byte, STOP. Every byte is acknowledged and the data is stored in register N. A second data byte in the same transaction is NACKed and not stored.
- R3: Byte read: START, 0xD4, command N, repeated START, 0xD5. The slave then returns the contents of register N.
- R4: Block write: command 0x00, then a count byte C, then data bytes. The first C data bytes are acknowledged and stored into registers 0, 1, 2 and upward. Every data byte after the first C is NACKed.
- R5: Block read: command 0x00, repeated START, 0xD5. The slave returns the count 7 first, then registers 0 through 6 in ascending order.
- R6: After reset, registers 5 and 6 read 0xFF and all ten pairs are enabled.
- R7: Registers 0 to 4 always read 0xFF, and writes to them change nothing. Reserved bits read as 1: bits 1 and 0 of register 5, and bits 7, 6, 5 and 0 of register 6.
- R8: Register 5 bits 7, 6, 5, 4, 3 and 2 enable pairs 0, 1, 2, 3, 4 and 9. Register 6 bits 4, 3, 2 and 1 enable pairs 8, 7, 6 and 5. A 1 enables the pair.
- R9: A STOP or START that arrives before a data byte is complete aborts the transfer without a register write. A START restarts address decoding.
- R10: Each true output equals the reference clock AND its enable, and each complement output is the inverse of its true output. An enable changes only while the reference clock is low.
- R11: The feedback output equals the reference clock at all times, whatever the register contents.
- R12: The slave changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain drive) |
| ref_clk | input | 1 | Reference clock to fan out |
| out_t | output | 10 | True outputs of the ten pairs |
| out_c | output | 10 | Complement outputs of the ten pairs |
| fb_t | output | 1 | Ungated feedback copy of the reference clock |

## Verification
The bench builds the block with its default parameters. These are address 0x6A, two synchroniser stages on the bus and two retiming stages toward the reference clock. The bench drives SCL with a half period of eight system clocks, so the three-cycle bus latency still leaves several cycles of set-up around every SCL edge.

A 14 ns reference clock runs against the 20 ns system clock, and the two have no fixed phase relationship. Enable updates therefore land at many different phases of the reference clock. This brings the glitch-free handover and the per-clock comparison of all twenty outputs against the model within reach.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  localparam int NPAIR = 10;
  localparam int NREG  = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_WR, ST_RD
  } smb_state_t;

  // register that holds the enable of pair p
  function automatic int pair_reg(input int p);
    if (p <= 4 || p == 9) return 5;
    return 6;
  endfunction

  // bit position of the enable of pair p inside its register
  function automatic int pair_bit(input int p);
    if (p <= 4) return 7 - p;
    if (p == 9) return 2;
    return p - 4;
  endfunction
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_raw};
      sda_sh <= {sda_sh[STAGES-2:0], sda_raw};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_q    = scl_sh[STAGES-1];
  assign sda_q    = sda_sh[STAGES-1];
  assign scl_rise = scl_q & ~scl_p;
  assign scl_fall = ~scl_q & scl_p;
  assign start_ev = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_ev  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/smb_proto.sv
module smb_proto
  import clkfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_q,
  input  logic       sda_q,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic       sda_pull,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] rd_addr
);
  smb_state_t st;
  logic [3:0] bitcnt;
  logic [7:0] sr, cmd, remain, ptr, idx, tx_byte;
  logic       rw, blk, done, ackd, mack, write_ok, byte_ack;

  assign write_ok = blk ? (remain != 8'd0) : !done;
  assign wr_en    = (st == ST_WR) && scl_fall && (bitcnt == 4'd8) && write_ok;
  assign wr_addr  = blk ? ptr : cmd;
  assign wr_data  = sr;
  assign rd_addr  = blk ? (idx - 8'd1) : cmd;
  assign tx_byte  = (blk && idx == 8'd0) ? 8'(NREG) : rd_data;

  always_comb begin
    case (st)
      ST_ADDR:        byte_ack = (sr[7:1] == DEV_ADDR);
      ST_CMD, ST_CNT: byte_ack = 1'b1;
      ST_WR:          byte_ack = write_ok;
      default:        byte_ack = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; sr <= '0; cmd <= '0; remain <= '0;
      ptr <= '0; idx <= '0; rw <= 1'b0; blk <= 1'b0; done <= 1'b0;
      ackd <= 1'b0; mack <= 1'b0; sda_pull <= 1'b0;
    end else if (start_ev) begin
      st <= ST_ADDR; bitcnt <= '0; sda_pull <= 1'b0; idx <= '0;
    end else if (stop_ev) begin
      st <= ST_IDLE; bitcnt <= '0; sda_pull <= 1'b0;
    end else if (st == ST_RD) begin
      if (scl_rise) begin
        if (bitcnt == 4'd8) begin
          mack <= !sda_q;
          bitcnt <= 4'd9;
        end else if (bitcnt < 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd9) begin
          if (mack) begin
            sr <= tx_byte; sda_pull <= !tx_byte[7]; idx <= idx + 8'd1; bitcnt <= '0;
          end else begin
            st <= ST_IDLE; sda_pull <= 1'b0;
          end
        end else if (bitcnt == 4'd8) begin
          sda_pull <= 1'b0;
        end else if (bitcnt != 4'd0) begin
          sr <= {sr[6:0], 1'b0};
          sda_pull <= !sr[6];
        end
      end
    end else if (st != ST_IDLE) begin
      if (scl_rise && bitcnt < 4'd8) begin
        sr <= {sr[6:0], sda_q};
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall && bitcnt == 4'd8) begin
        bitcnt <= 4'd9; ackd <= byte_ack; sda_pull <= byte_ack;
        case (st)
          ST_ADDR: rw <= sr[0];
          ST_CMD:  cmd <= sr;
          ST_CNT:  begin remain <= sr; ptr <= '0; end
          ST_WR:   if (wr_en) begin
                     if (blk) begin ptr <= ptr + 8'd1; remain <= remain - 8'd1; end
                     else done <= 1'b1;
                   end
          default: ;
        endcase
      end else if (scl_fall && bitcnt == 4'd9) begin
        sda_pull <= 1'b0; bitcnt <= '0;
        case (st)
          ST_ADDR: if (!ackd) st <= ST_IDLE;
                   else if (rw) begin
                     st <= ST_RD; sr <= tx_byte; sda_pull <= !tx_byte[7]; idx <= idx + 8'd1;
                   end else st <= ST_CMD;
          ST_CMD:  begin
                     blk <= (cmd == 8'd0); done <= 1'b0;
                     st <= (cmd == 8'd0) ? ST_CNT : ST_WR;
                   end
          ST_CNT:  st <= ST_WR;
          ST_WR:   if (!ackd) st <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  // R12
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_q |-> $stable(sda_pull));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull);
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import clkfan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic [NPAIR-1:0] en
);
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int RG = pair_reg(p);
    localparam int BT = pair_bit(p);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en[p] <= 1'b1;
      else if (wr_en && wr_addr == 8'(RG)) en[p] <= wr_data[BT];
    end
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int p = 0; p < NPAIR; p++)
      if (rd_addr == 8'(pair_reg(p))) rd_data[3'(pair_bit(p))] = en[p];
  end

  // R7
  rsv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr < 8'd5) |-> (rd_data == 8'hFF));
  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en));
endmodule

// File: rtl/pair_gate.sv
module pair_gate #(
  parameter int N      = 10,
  parameter int STAGES = 2
) (
  input  logic         ref_clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_in,
  output logic [N-1:0] out_t,
  output logic [N-1:0] out_c
);
  logic [N-1:0] sh [STAGES];
  logic [N-1:0] en_q, en_at_rise;

  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) sh[i] <= '1;
    end else begin
      sh[0] <= en_in;
      for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
    end
  end

  assign en_q  = sh[STAGES-1];
  assign out_t = {N{ref_clk}} & en_q;
  assign out_c = ~out_t;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) en_at_rise <= '1;
    else        en_at_rise <= en_q;
  end

  // R10
  gate_stable_chk: assert property (@(negedge ref_clk) disable iff (!rst_n)
    en_q == en_at_rise);
endmodule

// File: rtl/clkfan_ctl.sv
module clkfan_ctl
  import clkfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         BUS_SYNC = 2,
  parameter int         REF_SYNC = 2
) (
  input  logic             clk_sys,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  input  logic             ref_clk,
  output logic [NPAIR-1:0] out_t,
  output logic [NPAIR-1:0] out_c,
  output logic             fb_t
);
  logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev, wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [NPAIR-1:0] en;

  smb_sync #(.STAGES(BUS_SYNC)) u_sync (
    .clk(clk_sys), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  smb_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
    .clk(clk_sys), .rst_n(rst_n), .scl_q(scl_q), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .rd_data(rd_data), .sda_pull(sda_pull),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr));

  ctl_regs u_regs (
    .clk(clk_sys), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .en(en));

  pair_gate #(.N(NPAIR), .STAGES(REF_SYNC)) u_gate (
    .ref_clk(ref_clk), .rst_n(rst_n), .en_in(en), .out_t(out_t), .out_c(out_c));

  // R11: feedback pair is never gated
  assign fb_t = ref_clk;
endmodule

// File: tb/test_clkfan_ctl.sv
module test_clkfan_ctl;
  localparam int H = 8;
  logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, quiet = 1'b1;
  logic sda_pull, fb_t, sda_bus;
  logic [9:0] out_t, out_c, mdl;
  logic prev_pull, prev_scl;
  int total = 0, bad = 0;

  always #10 clk = ~clk;
  always #7 ref_clk = ~ref_clk;
  assign sda_bus = sda_m & ~sda_pull;

  clkfan_ctl i_clkfan_ctl (
    .clk_sys(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull(sda_pull), .ref_clk(ref_clk), .out_t(out_t), .out_c(out_c), .fb_t(fb_t));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // per-clock reference comparison (R10, R11, R12)
  always @(negedge clk) begin
    if (rst_n && !quiet) begin
      logic [9:0] et;
      et = ref_clk ? mdl : 10'h0;
      chk(out_t == et && out_c == ~et, "R10 pair outputs", int'(out_t), int'(et));
      chk(fb_t == ref_clk, "R11 feedback", int'(fb_t), int'(ref_clk));
    end
    if (rst_n && prev_scl && scl_m && sda_pull != prev_pull)
      chk(1'b0, "R12 sda changed while scl high", int'(sda_pull), int'(prev_pull));
    prev_pull = sda_pull;
    prev_scl  = scl_m;
  end

  function automatic logic [7:0] reg_img(input int r);
    if (r == 5) return {mdl[0], mdl[1], mdl[2], mdl[3], mdl[4], mdl[9], 2'b11};
    if (r == 6) return {3'b111, mdl[8], mdl[7], mdl[6], mdl[5], 1'b1};
    return 8'hFF;
  endfunction

  task automatic mdl_wr(input int r, input logic [7:0] d);
    if (r == 5) begin
      mdl[0] = d[7]; mdl[1] = d[6]; mdl[2] = d[5]; mdl[3] = d[4]; mdl[4] = d[3]; mdl[9] = d[2];
    end else if (r == 6) begin
      mdl[8] = d[4]; mdl[7] = d[3]; mdl[6] = d[2]; mdl[5] = d[1];
    end
  endtask

  task automatic wt(input int n); repeat (n) @(posedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0;
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output logic a);
    send_bits(b, 8);
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2);
    @(negedge clk) a = !sda_bus;
    wt(H/2); scl_m = 1'b0;
  endtask

  task automatic rbyte(input logic ack_m, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2);
      @(negedge clk) b = {b[6:0], sda_bus};
      wt(H/2); scl_m = 1'b0;
    end
    sda_m = !ack_m; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; sda_m = 1'b1;
  endtask

  task automatic byte_wr(input int r, input logic [7:0] d);
    logic a;
    quiet = 1'b1;
    i2c_start();
    wbyte(8'hD4, a); chk(a, "R1 write address ack", int'(a), 1);
    wbyte(8'(r), a); chk(a, "R2 command ack", int'(a), 1);
    wbyte(d, a);     chk(a, "R2 data ack", int'(a), 1);
    if (a) mdl_wr(r, d);
    i2c_stop(); wt(4); quiet = 1'b0;
  endtask

  task automatic byte_rd(input int r, output logic [7:0] b);
    logic a;
    i2c_start();
    wbyte(8'hD4, a); chk(a, "R3 address ack", int'(a), 1);
    wbyte(8'(r), a); chk(a, "R3 command ack", int'(a), 1);
    i2c_start();
    wbyte(8'hD5, a); chk(a, "R1 read address ack", int'(a), 1);
    rbyte(1'b0, b);
    i2c_stop();
  endtask

  task automatic blk_wr(input int cnt, input logic [7:0] d [8], input int nsend);
    logic a;
    quiet = 1'b1;
    i2c_start();
    wbyte(8'hD4, a); chk(a, "R4 address ack", int'(a), 1);
    wbyte(8'h00, a); chk(a, "R4 command ack", int'(a), 1);
    wbyte(8'(cnt), a); chk(a, "R4 count ack", int'(a), 1);
    for (int i = 0; i < nsend; i++) begin
      wbyte(d[i], a);
      chk(a == (i < cnt), "R4 data ack per count", int'(a), int'(i < cnt));
      if (a) mdl_wr(i, d[i]);
    end
    i2c_stop(); wt(4); quiet = 1'b0;
  endtask

  task automatic blk_rd();
    logic a;
    logic [7:0] b;
    i2c_start();
    wbyte(8'hD4, a); wbyte(8'h00, a);
    i2c_start();
    wbyte(8'hD5, a); chk(a, "R5 read address ack", int'(a), 1);
    rbyte(1'b1, b); chk(b == 8'd7, "R5 count byte", int'(b), 7);
    for (int i = 0; i < 7; i++) begin
      rbyte(i < 6, b);
      chk(b == reg_img(i), $sformatf("R5 block byte %0d", i), int'(b), int'(reg_img(i)));
    end
    i2c_stop();
  endtask

  initial begin
    logic [7:0] b;
    logic a;
    mdl = '1;
    prev_pull = 1'b0; prev_scl = 1'b1;
    wt(5);
    @(negedge clk) rst_n = 1'b1;
    wt(4); quiet = 1'b0;

    // R6: reset state at the pins and in the map
    @(negedge clk); while (!ref_clk) @(negedge clk);
    chk(out_t == 10'h3FF && out_c == 10'h0, "R6 all pairs on after reset", int'(out_t), 'h3FF);
    byte_rd(5, b); chk(b == 8'hFF, "R6 reg5 reset", int'(b), 'hFF);
    byte_rd(6, b); chk(b == 8'hFF, "R6 reg6 reset", int'(b), 'hFF);
    blk_rd();

    // R2 R3 R8: scattered bit map
    byte_wr(5, 8'hA5);
    byte_rd(5, b); chk(b == 8'hA7, "R8 reg5 map readback", int'(b), 'hA7);
    byte_wr(6, 8'h14);
    byte_rd(6, b); chk(b == 8'hF5, "R8 reg6 map readback", int'(b), 'hF5);

    // R7: reserved register write ignored
    byte_wr(2, 8'h00);
    byte_rd(2, b); chk(b == 8'hFF, "R7 reserved reg reads FF", int'(b), 'hFF);
    byte_rd(5, b); chk(b == 8'hA7, "R7 live reg untouched", int'(b), 'hA7);

    // R1: foreign address ignored
    quiet = 1'b1;
    i2c_start();
    wbyte(8'hD6, a); chk(!a, "R1 foreign address NACK", int'(a), 0);
    wbyte(8'h05, a); wbyte(8'h00, a);
    chk(!a, "R1 no ack after foreign address", int'(a), 0);
    i2c_stop(); wt(4); quiet = 1'b0;
    byte_rd(5, b); chk(b == 8'hA7, "R1 reg5 unchanged", int'(b), 'hA7);

    // R2: second data byte in byte mode NACKed
    quiet = 1'b1;
    i2c_start();
    wbyte(8'hD4, a); wbyte(8'h06, a);
    wbyte(8'hFF, a); chk(a, "R2 first data ack", int'(a), 1); mdl_wr(6, 8'hFF);
    wbyte(8'h00, a); chk(!a, "R2 extra data NACK", int'(a), 0);
    i2c_stop(); wt(4); quiet = 1'b0;
    byte_rd(6, b); chk(b == 8'hFF, "R2 extra byte not stored", int'(b), 'hFF);

    // R4 R5: block write full count plus one extra
    blk_wr(7, '{8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h50, 8'h0A, 8'h00}, 8);
    blk_rd();
    byte_rd(5, b); chk(b == 8'h53, "R4 block reg5", int'(b), 'h53);
    byte_rd(6, b); chk(b == 8'hEB, "R4 block reg6", int'(b), 'hEB);

    // R4: shorter count leaves register 6 alone
    blk_wr(6, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF8, 8'h00, 8'h00}, 7);
    byte_rd(5, b); chk(b == 8'hFB, "R4 short block reg5", int'(b), 'hFB);
    byte_rd(6, b); chk(b == 8'hEB, "R4 short block reg6 kept", int'(b), 'hEB);

    // R9: aborts
    quiet = 1'b1;
    i2c_start(); wbyte(8'hD4, a); wbyte(8'h05, a); i2c_stop();
    i2c_start(); wbyte(8'hD4, a); wbyte(8'h05, a); send_bits(8'h00, 4); i2c_stop();
    wt(4); quiet = 1'b0;
    byte_rd(5, b); chk(b == 8'hFB, "R9 stop abort no write", int'(b), 'hFB);
    quiet = 1'b1;
    i2c_start(); wbyte(8'hD4, a); wbyte(8'h06, a); send_bits(8'h00, 3);
    i2c_start();
    wbyte(8'hD4, a); chk(a, "R9 restart address ack", int'(a), 1);
    wbyte(8'h06, a); wbyte(8'h00, a); chk(a, "R9 data after restart", int'(a), 1);
    mdl_wr(6, 8'h00);
    i2c_stop(); wt(4); quiet = 1'b0;
    byte_rd(6, b); chk(b == 8'hE1, "R9 restart write landed", int'(b), 'hE1);

    // R10 R11: all pairs parked, feedback still running
    byte_wr(5, 8'h00);
    begin
      int errs = 0, fb_hi = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (out_t != 10'h0 || out_c != 10'h3FF) errs++;
        if (fb_t) fb_hi++;
      end
      chk(errs == 0, "R10 disabled pairs parked", errs, 0);
      chk(fb_hi > 0 && fb_hi < 60, "R11 feedback toggles", fb_hi, 30);
    end
    byte_wr(5, 8'hFF);
    byte_wr(6, 8'hFF);
    @(negedge clk); while (!ref_clk) @(negedge clk);
    chk(out_t == 10'h3FF, "R10 re-enabled pairs", int'(out_t), 'h3FF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule